// File: doc/BRIEF.md
# Conversion-Start Sequencer for a Sampling Converter

This block is the digital core of a sampling analog-to-digital converter. It decides when the track/hold captures the input and how long the conversion runs. It then loads the finished sample into an output register and announces the result with a short active-low end-of-conversion strobe. The analog front end and the serial port are not part of it. The converter core's 12-bit result arrives on a plain input bus and is captured when the conversion timer ends.

A conversion starts in one of two ways. The first is a rising edge on the hardware start pin, which holds the sample and begins conversion straight away. The second is a control-register write with its start bit set. A register start first runs an internal acquisition timer, so the multiplexer can settle on a channel written in the same word. Only then does the block hold and convert. A host reads the result by pulling chip-select and read low together. All durations are counted in clock cycles and set by parameters.

Top module: `cseq_top`

## Requirements
- R1: While reset is high and after it is released with no start: `hold` and `busy` are low, `eoc_n` is high, and the output register reads 0.
- R2: A low-to-high transition of `conv_start` seen while idle raises `hold` and `busy` at the next clock edge. A pin that is held high does not start a second conversion.
- R3: A write with `wr_data[3]` = 1 while idle raises `busy` at the next edge. `hold` then stays low for exactly ACQ_CYCLES cycles before it rises.
- R4: Bits `wr_data[2:0]` of every write appear on `chan` at the next edge. In a write that also sets the start bit, that channel is on `chan` when `hold` rises.
- R5: `hold` stays high for exactly CONV_CYCLES cycles. `hold` and `busy` fall together at the same edge.
- R6: At the edge where `hold` falls, the output register loads the value on `adc_result`, and `eoc_n` goes low for exactly EOC_CYCLES cycles.
- R7: A hardware edge or a register start bit that arrives while `busy` is high is ignored. The running conversion keeps its length, and no further conversion follows it.
- R8: A start accepted while `eoc_n` is still low begins a new conversion at once. It does not shorten or lengthen the strobe that is already running.
- R9: `data_out` drives the output register when `cs_n` and `rd_n` are both low. Otherwise it is high-impedance.
- R10: A hardware edge and a register start in the same idle cycle begin conversion with no acquisition delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Hardware start; a rising edge starts a conversion |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | 4 | Control word: bit 3 is the start bit, bits 2:0 are the channel |
| adc_result | input | 12 | Result from the converter core, captured when conversion ends |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read, active low |
| hold | output | 1 | Track/hold control, high while holding and converting |
| busy | output | 1 | High from an accepted start through the end of conversion |
| eoc_n | output | 1 | End-of-conversion strobe, active low |
| chan | output | 3 | Multiplexer channel select |
| data_out | output | 12 | Result bus, high-impedance unless read |

## Verification
Two pairs of events can land in the same cycle. In the first, a hardware edge and a register start bit arrive together while the block is idle. The bench drives both at one clock edge and judges the result by the zero-length acquisition phase. In the second, a new hardware start falls inside a running end-of-conversion strobe. The bench raises the pin on the first low cycle of the strobe. It then expects `hold` to be high while `eoc_n` is still low, the strobe to keep its full length, and a second scoreboard entry to be consumed by the following conversion. Starts injected in the middle of a conversion are judged by the conversion length that is measured and by `busy` staying low afterwards.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;

    localparam int DATA_W = 12;
    localparam int CH_W   = 3;
    localparam int CTRL_W = CH_W + 1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACQ  = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    // Control word: start bit on top, channel below it.
    typedef struct packed {
        logic            go;
        logic [CH_W-1:0] chan;
    } ctrl_word_t;

    typedef struct packed {
        logic hw;
        logic sw;
    } start_req_t;

    function automatic ctrl_word_t unpack_ctrl(input logic [CTRL_W-1:0] raw);
        unpack_ctrl = ctrl_word_t'(raw);
    endfunction

    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        cnt_width = (m < 1) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/cseq_start_detect.sv
`timescale 1ns/1ps
module cseq_start_detect
    import cseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output start_req_t        req,
    output logic [CH_W-1:0]   chan
);
    ctrl_word_t word;
    logic       pin_q;

    assign word = unpack_ctrl(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b1;      // a pin already high at reset is not an edge
            chan  <= '0;
        end else begin
            pin_q <= conv_start;
            if (wr_en) chan <= word.chan;
        end
    end

    always_comb begin
        req.hw = conv_start & ~pin_q;
        req.sw = wr_en & word.go;
    end
endmodule

// File: rtl/cseq_fsm.sv
`timescale 1ns/1ps
module cseq_fsm
    import cseq_pkg::*;
#(
    parameter int ACQ_CYCLES  = 120,
    parameter int CONV_CYCLES = 320
) (
    input  logic       clk,
    input  logic       rst,
    input  start_req_t req,
    output logic       hold,
    output logic       busy,
    output logic       conv_done
);
    localparam int CNT_W = cnt_width(ACQ_CYCLES, CONV_CYCLES);
    localparam logic [CNT_W-1:0] ACQ_LOAD  = CNT_W'(ACQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             last;

    assign last = (cnt == '0);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SEQ_IDLE: begin
                if (req.hw) begin
                    state_nx = SEQ_CONV;
                    cnt_nx   = CONV_LOAD;
                end else if (req.sw) begin
                    state_nx = SEQ_ACQ;
                    cnt_nx   = ACQ_LOAD;
                end
            end
            SEQ_ACQ: begin
                if (last) begin
                    state_nx = SEQ_CONV;
                    cnt_nx   = CONV_LOAD;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            SEQ_CONV: begin
                if (last) state_nx = SEQ_IDLE;
                else      cnt_nx   = cnt - 1'b1;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign hold      = (state == SEQ_CONV);
    assign busy      = (state != SEQ_IDLE);
    assign conv_done = (state == SEQ_CONV) && last;

    // R10: a hardware edge skips acquisition even when a register start comes with it
    assert_hw_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && req.hw) |=> (state == SEQ_CONV && cnt == CONV_LOAD));

    // R3: a register start alone enters acquisition with the sample still tracking
    assert_sw_waits_R3: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && req.sw && !req.hw) |=> (state == SEQ_ACQ && !hold));

    // R7: nothing disturbs a running conversion count
    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CONV && cnt != '0) |=> (state == SEQ_CONV && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cseq_eoc_gen.sv
`timescale 1ns/1ps
module cseq_eoc_gen #(
    parameter int EOC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic eoc_n
);
    localparam int EW = (EOC_CYCLES < 2) ? 1 : $clog2(EOC_CYCLES + 1);
    localparam logic [EW-1:0] EOC_LOAD = EW'(EOC_CYCLES);

    logic [EW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (fire)        left <= EOC_LOAD;
        else if (left != '0)  left <= left - 1'b1;
    end

    assign eoc_n = (left == '0);

    // R6: the strobe always starts at its full length
    assert_eoc_start_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!eoc_n && left == EOC_LOAD));
endmodule

// File: rtl/cseq_out_reg.sv
`timescale 1ns/1ps
module cseq_out_reg
    import cseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] adc_result,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] result;

    always_ff @(posedge clk) begin
        if (rst)          result <= '0;
        else if (capture) result <= adc_result;
    end

    assign data_out = (!cs_n && !rd_n) ? result : {DATA_W{1'bz}};
endmodule

// File: rtl/cseq_top.sv
`timescale 1ns/1ps
module cseq_top
    import cseq_pkg::*;
#(
    parameter int ACQ_CYCLES  = 120,
    parameter int CONV_CYCLES = 320,
    parameter int EOC_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [DATA_W-1:0] adc_result,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              hold,
    output logic              busy,
    output logic              eoc_n,
    output logic [CH_W-1:0]   chan,
    output logic [DATA_W-1:0] data_out
);
    start_req_t req;
    logic       conv_done;

    cseq_start_detect u_detect (
        .clk(clk), .rst(rst), .conv_start(conv_start),
        .wr_en(wr_en), .wr_data(wr_data), .req(req), .chan(chan)
    );

    cseq_fsm #(.ACQ_CYCLES(ACQ_CYCLES), .CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk(clk), .rst(rst), .req(req),
        .hold(hold), .busy(busy), .conv_done(conv_done)
    );

    cseq_eoc_gen #(.EOC_CYCLES(EOC_CYCLES)) u_eoc (
        .clk(clk), .rst(rst), .fire(conv_done), .eoc_n(eoc_n)
    );

    cseq_out_reg u_out (
        .clk(clk), .rst(rst), .capture(conv_done), .adc_result(adc_result),
        .cs_n(cs_n), .rd_n(rd_n), .data_out(data_out)
    );

    // R6: the strobe begins exactly when the hold ends
    assert_eoc_with_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_n) |-> $fell(hold));

    // R5: busy is released together with the hold
    assert_busy_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> $fell(busy));
endmodule

// File: tb/tb_cseq_top.sv
`timescale 1ns/1ps
module tb_cseq_top;
    localparam int ACQ  = 5;
    localparam int CONV = 8;
    localparam int EOC  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_data = '0;
    logic [11:0] adc_result = '0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hold, busy, eoc_n;
    logic [2:0]  chan;
    logic [11:0] data_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [11:0] exp_q[$];

    always #2.5 clk = ~clk;

    cseq_top #(.ACQ_CYCLES(ACQ), .CONV_CYCLES(CONV), .EOC_CYCLES(EOC)) dut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .wr_en(wr_en),
        .wr_data(wr_data), .adc_result(adc_result), .cs_n(cs_n), .rd_n(rd_n),
        .hold(hold), .busy(busy), .eoc_n(eoc_n), .chan(chan), .data_out(data_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: reads each result as its strobe appears and compares it with the scoreboard.
    initial begin
        logic [11:0] e;
        @(negedge rst);
        forever begin
            @(negedge eoc_n);
            #0.6;
            cs_n = 1'b0; rd_n = 1'b0;
            #0.6;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected result", int'(data_out), -1);
            end else begin
                e = exp_q.pop_front();
                chk(data_out === e, "R6 captured value", int'(data_out), int'(e));
            end
            cs_n = 1'b1; rd_n = 1'b1;
            #0.6;
            chk(data_out === 12'bz, "R9 bus released", int'(data_out), 0);
        end
    end

    // Driver: starts one conversion, pushes its expected result and times every phase.
    task automatic run_conv(input bit use_hw, input bit use_sw, input logic [2:0] ch,
                            input logic [11:0] val, input bit inject, input bit keep,
                            input bit b2b);
        int acq = 0;
        int conv = 0;
        int eoc = 0;
        int guard = 0;
        bit saw_hold = 0;
        int exp_acq = use_hw ? 0 : ACQ;
        @(negedge clk);
        adc_result = val;
        exp_q.push_back(val);
        if (b2b) exp_q.push_back(val);
        if (use_hw) conv_start = 1'b1;
        if (use_sw) begin wr_en = 1'b1; wr_data = {1'b1, ch}; end
        @(negedge clk);
        if (!keep) conv_start = 1'b0;
        wr_en = 1'b0;
        chk(busy === 1'b1, "R2 R3 busy after start", int'(busy), 1);
        if (use_hw) chk(hold === 1'b1, "R2 R10 immediate hold", int'(hold), 1);
        while (busy && !hold && guard < 1000) begin
            acq++; guard++;
            @(negedge clk);
        end
        chk(acq == exp_acq, use_hw ? "R10 acquisition length" : "R3 acquisition length", acq, exp_acq);
        if (use_sw) chk(chan === ch, "R4 channel at hold", int'(chan), int'(ch));
        while (hold && guard < 1000) begin
            conv++; guard++;
            if (inject && conv == 2) begin
                conv_start = 1'b1; wr_en = 1'b1; wr_data = 4'b1111;
            end
            @(negedge clk);
            if (!keep) conv_start = 1'b0;
            wr_en = 1'b0;
        end
        chk(conv == CONV, inject ? "R7 conversion length with starts injected" : "R5 conversion length", conv, CONV);
        chk(busy === 1'b0 && eoc_n === 1'b0, "R5 R6 busy off and strobe on", int'({busy, eoc_n}), 0);
        while (!eoc_n && guard < 1000) begin
            eoc++; guard++;
            if (b2b && eoc == 1) conv_start = 1'b1;
            @(negedge clk);
            if (!keep) conv_start = 1'b0;
            if (hold) saw_hold = 1;
        end
        chk(eoc == EOC, b2b ? "R8 strobe length with new start" : "R6 strobe length", eoc, EOC);
        if (b2b) begin
            chk(saw_hold, "R8 hold during strobe", int'(saw_hold), 1);
            while ((busy || !eoc_n) && guard < 1000) begin
                guard++;
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, keep ? "R2 no retrigger from level" : "R7 no follow-on conversion", int'(busy), 0);
        conv_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(hold === 1'b0 && busy === 1'b0, "R1 hold and busy in reset", int'({hold, busy}), 0);
        chk(eoc_n === 1'b1, "R1 strobe idle in reset", int'(eoc_n), 1);
        chk(data_out === 12'bz, "R9 bus idle", int'(data_out), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #0.5;
        chk(data_out === 12'h000, "R1 R9 result after reset", int'(data_out), 0);
        cs_n = 1'b1;
        #0.5;
        chk(data_out === 12'bz, "R9 read without select", int'(data_out), 0);
        cs_n = 1'b1; rd_n = 1'b1;

        // channel write without a start bit: no conversion
        @(negedge clk);
        wr_en = 1'b1; wr_data = 4'b0011;
        @(negedge clk);
        wr_en = 1'b0;
        chk(chan === 3'd3, "R4 channel write", int'(chan), 3);
        chk(busy === 1'b0, "R4 write without start bit", int'(busy), 0);

        run_conv(1, 0, 3'd0, 12'hA5C, 0, 0, 0);
        run_conv(0, 1, 3'd5, 12'h3F1, 0, 0, 0);
        run_conv(0, 1, 3'd2, 12'hFFF, 1, 0, 0);
        run_conv(1, 1, 3'd6, 12'h000, 0, 0, 0);
        run_conv(1, 0, 3'd0, 12'h5A5, 0, 1, 0);
        run_conv(1, 0, 3'd0, 12'h801, 0, 0, 1);
        run_conv(0, 1, 3'd7, 12'h7FE, 0, 0, 0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R6 every result delivered", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule